// File: doc/BRIEF.md
# SMBus Slave Address Acknowledge Controller

This block is the slave half of an SMBus/I2C port that deals with the first byte after a START. It watches SCL and SDA and shifts in the address byte, most significant bit first. It then decides whether to pull SDA low during the following acknowledge clock. Two addresses are answered: a programmable 7-bit own address, and the general call address (all zeros with the write direction). Software can withdraw the device from the bus with an acknowledge-enable bit. This stops it answering either address, while the block keeps following START, STOP and bus occupancy.

When an address is acknowledged, the block raises an interrupt flag and publishes a 2-bit status code. The code tells software whether it saw an own-address write, an own-address read or a general call. While the flag is pending and SCL is low, the block holds SCL low, so the transfer waits for software. A software stop request returns the slave to the not-addressed state without putting anything on the bus. The bus stays marked busy until a real STOP or an idle timeout.

Top module: `smb_slave_ack`

## Requirements
- R1: With `ack_en`=1 and the received address byte equal to {`own_addr`, direction}, the block drives SDA low from the SCL falling edge after the eighth bit until the next SCL falling edge, and `addressed` is 1 during that time.
- R2: With `ack_en`=0, no address (own or general call) is acknowledged: SDA is never driven, `irq_flag` stays 0 and `addressed` stays 0.
- R3: Address byte 8'h00 (7-bit address 0, direction bit 0 = write) is acknowledged as a general call when `ack_en`=1. Address 0 with direction bit 1 is not acknowledged.
- R4: Any other address byte is not acknowledged: SDA stays released, with no interrupt and no addressed state.
- R5: On every acknowledge, `irq_flag` becomes 1 and `status` holds 1 for an own-address write (bit 0 = 0), 2 for an own-address read (bit 0 = 1) and 3 for a general call. A one-cycle `irq_clr` pulse clears the flag.
- R6: While `irq_flag`=1 and the sampled SCL is low, `scl_drive_low` is 1. After `irq_clr`, SCL is released.
- R7: A one-cycle `stop_set` pulse makes the slave not addressed and releases SDA. It sets `stop_req` and leaves `bus_busy` at 1. Bits that follow without a START are then ignored.
- R8: A real STOP (SDA rising while SCL is high) clears `stop_req` and `bus_busy`.
- R9: A START sets `bus_busy`. If SCL and SDA both stay high for `TIMEOUT_CYC` cycles without a STOP, `bus_busy` is cleared.
- R10: A repeated START in the middle of a byte restarts address reception from the first bit.
- R11: After reset, every output is 0.
- R12: Setting `ack_en` back to 1 after a refused address restores recognition for the next address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| own_addr | input | ADDR_W | Programmable own slave address |
| ack_en | input | 1 | Acknowledge enable from software |
| stop_set | input | 1 | One-cycle software stop request |
| irq_clr | input | 1 | One-cycle interrupt flag clear |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (ACK) |
| irq_flag | output | 1 | Interrupt flag pending |
| status | output | 2 | Address-phase result code |
| stop_req | output | 1 | Software stop request bit |
| bus_busy | output | 1 | Bus occupied between START and STOP/timeout |
| addressed | output | 1 | Slave currently addressed |

## Verification
The bench sweeps all 128 addresses in both directions with acknowledge enabled and disabled, and compares the ACK level, interrupt and status with values computed from the address arithmetic.
- A design that confused the direction bit would acknowledge a general call read.
- A design that ignored the enable would answer with `ack_en` low.
- A design that released SCL while the flag is set would let the master run ahead of software.

Directed cases cover the software stop, a repeated START in the middle of a byte and the idle timeout:
- The software stop must keep the bus busy and leave later bits without a START unanswered. A version that freed the bus or kept shifting would show up there.
- The repeated START catches a bit counter that is not restarted.
- The idle timeout catches a timer that never frees the bus, or one that frees it early.

// File: rtl/smb_ack_pkg.sv
package smb_ack_pkg;
  localparam int STAT_W = 2;

  typedef enum logic [STAT_W-1:0] {
    ST_NONE   = 2'd0,
    ST_OWN_WR = 2'd1,
    ST_OWN_RD = 2'd2,
    ST_GCALL  = 2'd3
  } smb_stat_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_ACK   = 2'd2,
    PH_SELD  = 2'd3
  } smb_phase_e;
endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_in;
          sda_sh <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
          sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_lvl;
      sda_p <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_sh[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_p;
  assign scl_fall  = ~scl_lvl & scl_p;
  assign start_det = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/smb_busfree.sv
module smb_busfree #(
  parameter int TIMEOUT_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic scl_lvl,
  input  logic sda_lvl,
  output logic bus_busy,
  output logic timeout
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic busy_q, busy_n;
  logic idle_hi;

  assign idle_hi = busy_q & scl_lvl & sda_lvl;
  assign timeout = idle_hi & (cnt_q == CNT_LAST);

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (idle_hi) cnt_n = cnt_q + 1'b1;
    else         cnt_n = '0;
    if (start_det) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (stop_det || timeout) begin
      busy_n = 1'b0;
      cnt_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  assign bus_busy = busy_q;
endmodule

// File: rtl/smb_addr_fsm.sv
module smb_addr_fsm
  import smb_ack_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              stop_set,
  input  logic              irq_clr,
  output logic              sda_drive_low,
  output logic              irq_flag,
  output logic [STAT_W-1:0] status,
  output logic              stop_req,
  output logic              addressed
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int BCNT_W = $clog2(BYTE_W + 1);
  localparam logic [BCNT_W-1:0] BCNT_FULL = BCNT_W'(BYTE_W);

  smb_phase_e        ph_q, ph_n;
  logic [BYTE_W-1:0] rx_q, rx_n;
  logic [BCNT_W-1:0] bc_q, bc_n;
  smb_stat_e         st_q, st_n;
  logic              irq_q, irq_n;
  logic              sreq_q, sreq_n;
  logic              own_hit, gc_hit, take;
  logic              irq_set;

  assign own_hit = (rx_q[BYTE_W-1:1] == own_addr);
  assign gc_hit  = (rx_q[BYTE_W-1:1] == '0) & ~rx_q[0];
  assign take    = ack_en & (own_hit | gc_hit);

  always_comb begin
    ph_n    = ph_q;
    rx_n    = rx_q;
    bc_n    = bc_q;
    st_n    = st_q;
    irq_set = 1'b0;
    if (start_det) begin
      ph_n = PH_ADDR;
      bc_n = '0;
    end else if (stop_det || stop_set) begin
      ph_n = PH_IDLE;
    end else begin
      case (ph_q)
        PH_ADDR: begin
          if (scl_rise && bc_q != BCNT_FULL) begin
            rx_n = {rx_q[BYTE_W-2:0], sda_lvl};
            bc_n = bc_q + 1'b1;
          end else if (scl_fall && bc_q == BCNT_FULL) begin
            if (take) begin
              ph_n    = PH_ACK;
              irq_set = 1'b1;
              if (gc_hit)     st_n = ST_GCALL;
              else if (rx_q[0]) st_n = ST_OWN_RD;
              else            st_n = ST_OWN_WR;
            end else begin
              ph_n = PH_IDLE;
            end
          end
        end
        PH_ACK:  if (scl_fall) ph_n = PH_SELD;
        default: ph_n = ph_q;
      endcase
    end
  end

  always_comb begin
    irq_n = irq_q;
    if (irq_clr) irq_n = 1'b0;
    if (irq_set) irq_n = 1'b1;
    sreq_n = sreq_q;
    if (stop_det) sreq_n = 1'b0;
    if (stop_set) sreq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      rx_q   <= '0;
      bc_q   <= '0;
      st_q   <= ST_NONE;
      irq_q  <= 1'b0;
      sreq_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      rx_q   <= rx_n;
      bc_q   <= bc_n;
      st_q   <= st_n;
      irq_q  <= irq_n;
      sreq_q <= sreq_n;
    end
  end

  assign sda_drive_low = (ph_q == PH_ACK);
  assign addressed     = (ph_q == PH_ACK) | (ph_q == PH_SELD);
  assign irq_flag      = irq_q;
  assign status        = st_q;
  assign stop_req      = sreq_q;
endmodule

// File: rtl/smb_slave_ack.sv
module smb_slave_ack #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              stop_set,
  input  logic              irq_clr,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              irq_flag,
  output logic [1:0]        status,
  output logic              stop_req,
  output logic              bus_busy,
  output logic              addressed
);
  logic [1:0] rst_pipe;
  logic rst_n_s;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det, timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  smb_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n_s), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  smb_busfree #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_free (
    .clk(clk), .rst_n(rst_n_s), .start_det(start_det), .stop_det(stop_det),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .bus_busy(bus_busy), .timeout(timeout)
  );

  smb_addr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .ack_en(ack_en), .stop_set(stop_set),
    .irq_clr(irq_clr), .sda_drive_low(sda_drive_low), .irq_flag(irq_flag),
    .status(status), .stop_req(stop_req), .addressed(addressed)
  );

  assign scl_drive_low = irq_flag & ~scl_lvl;
endmodule

// File: rtl/smb_ack_checker.sv
module smb_ack_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_en,
  input logic       stop_set,
  input logic       start_det,
  input logic       stop_det,
  input logic       timeout,
  input logic       scl_drive_low,
  input logic       sda_drive_low,
  input logic       irq_flag,
  input logic [1:0] status,
  input logic       stop_req,
  input logic       bus_busy,
  input logic       addressed
);
  AST_ACK_ONLY_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> addressed); // R1
  AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> $past(ack_en)); // R2
  AST_ACK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> (irq_flag && status != 2'd0)); // R5
  AST_STRETCH_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> irq_flag); // R6
  AST_SWSTOP_UNADDRESSES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_set && !start_det) |=> !addressed); // R7
  AST_SWSTOP_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_set && bus_busy && !stop_det && !timeout) |=> bus_busy); // R7
  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !stop_set) |=> (!stop_req && !bus_busy)); // R8
  AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bus_busy); // R9
endmodule

bind smb_slave_ack smb_ack_checker u_chk (
  .clk(clk), .rst_n(rst_n_s), .ack_en(ack_en), .stop_set(stop_set),
  .start_det(start_det), .stop_det(stop_det), .timeout(timeout),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
  .irq_flag(irq_flag), .status(status), .stop_req(stop_req),
  .bus_busy(bus_busy), .addressed(addressed)
);

// File: tb/smb_slave_ack_bench.sv
module smb_slave_ack_bench;
  localparam int Q    = 5;
  localparam int TO   = 40;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic [6:0] own_addr;
  logic ack_en, stop_set, irq_clr;
  logic scl_drive_low, sda_drive_low, irq_flag, stop_req, bus_busy, addressed;
  logic [1:0] status;
  logic scl_bus, sda_bus;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign scl_bus = scl_m & ~scl_drive_low;
  assign sda_bus = sda_m & ~sda_drive_low;

  smb_slave_ack #(.ADDR_W(7), .SYNC_STAGES(1), .TIMEOUT_CYC(TO)) u_smb_slave_ack (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .own_addr(own_addr), .ack_en(ack_en), .stop_set(stop_set), .irq_clr(irq_clr),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .irq_flag(irq_flag), .status(status), .stop_req(stop_req),
    .bus_busy(bus_busy), .addressed(addressed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic do_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic xact(input logic [6:0] a, input logic rw, input logic en, input string tag);
    bit exp_ack;
    int exp_st;
    exp_ack = en && (a == OWN || (a == 7'd0 && !rw));
    exp_st  = (a == 7'd0 && !rw) ? 3 : (rw ? 2 : 1);
    ack_en = en;
    do_start();
    send_byte({a, rw});
    sda_m = 1'b1; wq();
    chk(sda_bus == !exp_ack, tag, sda_bus, !exp_ack);
    chk(irq_flag == exp_ack, "R5 irq", irq_flag, exp_ack);
    if (exp_ack) chk(status == exp_st, "R5 status", status, exp_st);
    scl_m = 1'b1; wq();
    if (exp_ack) begin
      chk(scl_bus == 1'b0, "R6 stretch", scl_bus, 0);
      pulse_clr(); wq();
      chk(scl_bus == 1'b1, "R6 release", scl_bus, 1);
      chk(sda_bus == 1'b0, "R1 ack held in high", sda_bus, 0);
    end
    scl_m = 1'b0; wq();
    chk(sda_drive_low == 1'b0, "R1 ack released", sda_drive_low, 0);
    chk(addressed == exp_ack, {tag, " addressed"}, addressed, exp_ack);
    do_stop();
    chk(bus_busy == 1'b0, "R8 busy after stop", bus_busy, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    string tg;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    own_addr = OWN; ack_en = 1'b0; stop_set = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11
    chk({scl_drive_low, sda_drive_low, irq_flag, status, stop_req, bus_busy, addressed} == 8'd0,
        "R11 reset", {scl_drive_low, sda_drive_low, irq_flag, status, stop_req, bus_busy, addressed}, 0);

    // sweep: R1 R2 R3 R4 R5 R6
    for (int en = 0; en < 2; en++)
      for (int rw = 0; rw < 2; rw++)
        for (int a = 0; a < 128; a++) begin
          if (en == 0) tg = "R2";
          else if (a == OWN) tg = "R1";
          else if (a == 0) tg = "R3";
          else tg = "R4";
          xact(7'(a), rw[0], en[0], tg);
        end

    // R12: refused then restored
    xact(OWN, 1'b0, 1'b0, "R12 refused");
    xact(OWN, 1'b1, 1'b1, "R12 restored");

    // R7: software stop during the acknowledge clock
    ack_en = 1'b1;
    do_start();
    send_byte({OWN, 1'b0});
    sda_m = 1'b1; wq();
    chk(sda_drive_low == 1'b1, "R7 ack before swstop", sda_drive_low, 1);
    stop_set = 1'b1; @(negedge clk); stop_set = 1'b0; wq();
    chk(sda_drive_low == 1'b0, "R7 sda released", sda_drive_low, 0);
    chk(addressed == 1'b0, "R7 not addressed", addressed, 0);
    chk(stop_req == 1'b1, "R7 stop_req set", stop_req, 1);
    chk(bus_busy == 1'b1, "R7 bus still busy", bus_busy, 1);
    pulse_clr(); wq();
    scl_m = 1'b1; wq();
    scl_m = 1'b0; wq();
    send_byte({OWN, 1'b0});
    sda_m = 1'b1; wq();
    chk(sda_drive_low == 1'b0, "R7 no ack without start", sda_drive_low, 0);
    chk(irq_flag == 1'b0, "R7 no irq without start", irq_flag, 0);
    scl_m = 1'b1; wq();
    scl_m = 1'b0; wq();
    do_stop();
    chk(stop_req == 1'b0, "R8 stop_req cleared", stop_req, 0);
    chk(bus_busy == 1'b0, "R8 bus freed", bus_busy, 0);

    // R10: repeated start in the middle of a byte
    do_start();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    sda_m = 1'b1; wq();
    do_start();
    send_byte({OWN, 1'b1});
    sda_m = 1'b1; wq();
    chk(sda_bus == 1'b0, "R10 ack after restart", sda_bus, 0);
    chk(status == 2'd2, "R10 status read", status, 2);
    scl_m = 1'b1; wq();
    pulse_clr(); wq();
    scl_m = 1'b0; wq();
    do_stop();

    // R9: idle timeout frees the bus
    do_start();
    chk(bus_busy == 1'b1, "R9 busy after start", bus_busy, 1);
    sda_m = 1'b1; wq();
    scl_m = 1'b1;
    repeat (TO - 10) @(negedge clk);
    chk(bus_busy == 1'b1, "R9 busy before timeout", bus_busy, 1);
    repeat (20) @(negedge clk);
    chk(bus_busy == 1'b0, "R9 free after timeout", bus_busy, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule